// File: doc/BRIEF.md
# SPI Controller Register Front-End

This block is the word-addressed register side of an SPI master. A host writes and reads a small set of registers. They hold a configuration word with a clock-gate bit, a controller enable shared with four slave-select lines, a baud divisor, and one register that carries the receive and transmit FIFO thresholds. Transmit and receive FIFOs sit behind a single data register. That register only acts when the host sets a strobe bit in the written word, and a direction bit in the same word chooses between loading the transmit FIFO and unloading the receive FIFO.

The serial shift engine is not part of this block. A stub port stands in for it. The engine side sees the oldest transmit word and can take it. It can also hand a received word to the receive FIFO. Both actions count only while the controller is enabled and its clock gate is open. Five interrupt conditions are collected. Three are sticky error flags and two are live FIFO-threshold conditions. After the mask is applied they drive three separate interrupt lines: receive, transmit and error.

Top module: `spi_reg_frontend`

## Requirements
- R1: After reset, control, enable, baud, thresholds and mask read 0, both FIFO levels read 0, status reads 0x06, and all three interrupt lines are low.
- R2: Registers decode at these word offsets: control 0x0, enable 0x2, baud 0x4, thresholds 0x5, TX level 0x7, RX level 0x8, status 0x9, interrupt status 0xa, mask 0xb, clear 0xc, data 0xd. Every other offset reads 0.
- R3: Control bit 15 is the clock gate. A control write with wdata[16]=0 updates bits 14:0 and leaves bit 15 unchanged. A write with wdata[16]=1 updates only bit 15. Engine pops and pushes are ignored unless bit 15 and the enable bit are both 1 (eng_active).
- R4: Enable register bit 0 is the controller enable and bits 7:4 drive ss_sel. Reads return both fields.
- R5: In the threshold register, bits 15:0 are the RX threshold and bits 31:16 are the TX threshold. wr_half[0] gates the write of the low half and wr_half[1] gates the write of the high half. A half that is not selected keeps its value.
- R6: A data write with bits 31 and 30 both set pushes wdata[15:0] into the TX FIFO. The TX level counts up, and eng_tx_data presents the oldest entry.
- R7: A data write with bit 31 set and bit 30 clear pops the oldest RX entry into a holding register. Data reads return that holding register, in arrival order.
- R8: A data write with bit 31 clear changes neither FIFO nor the holding register.
- R9: A push into a full TX FIFO (8 entries) drops the word and sets TX overflow. A pop of an empty RX FIFO loads 0 and sets RX underflow. An engine push into a full RX FIFO sets RX overflow.
- R10: Interrupt status bits are [0] TX level ≤ TX threshold (while enabled), [1] TX overflow, [2] RX underflow, [3] RX overflow, [4] RX level > RX threshold. Each bit is masked by the same mask bit. Writing 1 to a bit of the clear register clears that sticky flag, and 0x1f clears them all.
- R11: irq_tx is masked bit 0, irq_err is the OR of masked bits 3:1, and irq_rx is masked bit 4.
- R12: While the enable bit is 0, both FIFOs are emptied and both levels read 0.
- R13: Status bits are [0] busy (eng_active and TX not empty), [1] TX not full, [2] TX empty, [3] RX not empty, [4] RX full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word offset |
| wdata | input | 32 | Write data |
| wr_half | input | 2 | Half-select for threshold writes |
| rdata | output | 32 | Read data for addr (combinational) |
| eng_active | output | 1 | Engine clock open and controller enabled |
| eng_tx_avail | output | 1 | TX word available to engine |
| eng_tx_data | output | 16 | Oldest TX FIFO word |
| eng_pop | input | 1 | Engine takes the TX word |
| eng_push | input | 1 | Engine delivers an RX word |
| eng_rx_data | input | 16 | Word delivered by the engine |
| ss_sel | output | 4 | Slave-select field |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_err | output | 1 | Error interrupt line |

## Verification
The data register is driven with the three command patterns: push (bits 31 and 30 set), pop (31 set, 30 clear) and no strobe. Each is checked through the level registers and the holding register, which shows whether the strobe and direction bits are decoded separately. Pushes and pops are run empty-to-full and then one past the full or empty point, which separates normal operation from the overflow and underflow paths. The control and threshold registers are written with partial-update selects, which shows whether the preserved fields survive. Mask patterns that select only one source show whether each interrupt line follows its own sources.

// File: rtl/spi_reg_frontend.sv
module spi_reg_frontend #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        wr_half,
  output logic [31:0]       rdata,
  output logic              eng_active,
  output logic              eng_tx_avail,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_pop,
  input  logic              eng_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic [3:0]        ss_sel,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_err
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  localparam logic [3:0] A_CTRL = 4'h0, A_EN = 4'h2, A_BAUD = 4'h4, A_THR = 4'h5,
                         A_TXL = 4'h7, A_RXL = 4'h8, A_SR = 4'h9, A_ISR = 4'ha,
                         A_IMR = 4'hb, A_ICR = 4'hc, A_DR = 4'hd;

  logic [15:0] ctrl, baud, rx_thr, tx_thr;
  logic        en;
  logic [3:0]  ss;
  logic [4:0]  imask;
  logic        txo, rxu, rxo;
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] tx_mem [DEPTH];
  logic [DATA_W-1:0] rx_mem [DEPTH];
  logic [PTR_W-1:0]  tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_dr   = wr_en && addr == A_DR;
  wire wr_icr  = wr_en && addr == A_ICR;

  wire host_push = wr_dr & wdata[31] & wdata[30];
  wire host_pop  = wr_dr & wdata[31] & ~wdata[30];

  wire tx_full  = tx_lvl == FULL;
  wire rx_full  = rx_lvl == FULL;
  wire tx_empty = tx_lvl == '0;
  wire rx_empty = rx_lvl == '0;

  assign eng_active   = ctrl[15] & en;
  assign eng_tx_avail = eng_active & ~tx_empty;
  assign eng_tx_data  = tx_mem[tx_rp];
  assign ss_sel       = ss;

  wire push_ok     = host_push & en & ~tx_full;
  wire txo_set     = host_push & en & tx_full;
  wire epop_ok     = eng_pop & eng_active & ~tx_empty;
  wire pop_ok      = host_pop & ~rx_empty;
  wire rxu_set     = host_pop & rx_empty;
  wire epush_ok    = eng_push & eng_active & ~rx_full;
  wire rxo_set     = eng_push & eng_active & rx_full;

  wire txe_cond = en & (16'(tx_lvl) <= tx_thr);
  wire rxf_cond = en & (16'(rx_lvl) > rx_thr);
  wire [4:0] raw = {rxf_cond, rxo, rxu, txo, txe_cond};
  wire [4:0] isr = raw & imask;

  assign irq_tx  = isr[0];
  assign irq_err = |isr[3:1];
  assign irq_rx  = isr[4];

  wire [4:0] sr = {rx_full, ~rx_empty, tx_empty, ~tx_full, eng_active & ~tx_empty};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      baud   <= '0;
      rx_thr <= '0;
      tx_thr <= '0;
      en     <= 1'b0;
      ss     <= '0;
      imask  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: if (wdata[16]) ctrl[15] <= wdata[15];
                else           ctrl[14:0] <= wdata[14:0];
        A_EN:   begin en <= wdata[0]; ss <= wdata[7:4]; end
        A_BAUD: baud <= wdata[15:0];
        A_THR:  begin
                  if (wr_half[0]) rx_thr <= wdata[15:0];
                  if (wr_half[1]) tx_thr <= wdata[31:16];
                end
        A_IMR:  imask <= wdata[4:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txo <= 1'b0;
      rxu <= 1'b0;
      rxo <= 1'b0;
    end else begin
      txo <= (txo & ~(wr_icr & wdata[1])) | txo_set;
      rxu <= (rxu & ~(wr_icr & wdata[2])) | rxu_set;
      rxo <= (rxo & ~(wr_icr & wdata[3])) | rxo_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_lvl <= '0;
    end else if (!en) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_lvl <= '0;
    end else begin
      if (push_ok) tx_wp <= tx_wp + 1'b1;
      if (epop_ok) tx_rp <= tx_rp + 1'b1;
      tx_lvl <= tx_lvl + LVL_W'(push_ok) - LVL_W'(epop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) tx_mem[tx_wp] <= wdata[DATA_W-1:0];
    if (epush_ok) rx_mem[rx_wp] <= eng_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_lvl <= '0;
    end else if (!en) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_lvl <= '0;
    end else begin
      if (epush_ok) rx_wp <= rx_wp + 1'b1;
      if (pop_ok)   rx_rp <= rx_rp + 1'b1;
      rx_lvl <= rx_lvl + LVL_W'(epush_ok) - LVL_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold <= '0;
    else if (pop_ok)   hold <= rx_mem[rx_rp];
    else if (rxu_set)  hold <= '0;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {16'h0, ctrl};
      A_EN:    rdata = {24'h0, ss, 3'b000, en};
      A_BAUD:  rdata = {16'h0, baud};
      A_THR:   rdata = {tx_thr, rx_thr};
      A_TXL:   rdata = 32'(tx_lvl);
      A_RXL:   rdata = 32'(rx_lvl);
      A_SR:    rdata = {27'h0, sr};
      A_ISR:   rdata = {27'h0, isr};
      A_IMR:   rdata = {27'h0, imask};
      A_DR:    rdata = 32'(hold);
      default: rdata = '0;
    endcase
  end
endmodule

module spi_reg_frontend_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       addr,
  input logic [31:0]      wdata,
  input logic             en,
  input logic             eng_active,
  input logic             eng_pop,
  input logic             eng_push,
  input logic [LVL_W-1:0] tx_lvl,
  input logic [LVL_W-1:0] rx_lvl,
  input logic [4:0]       imask,
  input logic             irq_err
);
  // R6
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= LVL_W'(DEPTH));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl == LVL_W'(DEPTH) && wr_en && addr == 4'hd && wdata[31] && wdata[30] && !eng_pop)
    |=> tx_lvl == LVL_W'(DEPTH));

  // R8
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && addr == 4'hd && !wdata[31] && !eng_pop && !eng_push)
    |=> ($stable(tx_lvl) && $stable(rx_lvl)));

  // R12
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_lvl == '0 && rx_lvl == '0));

  // R3
  gated_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_active && en) |=> tx_lvl >= $past(tx_lvl));

  // R11
  err_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (|imask[3:1]));
endmodule

bind spi_reg_frontend spi_reg_frontend_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .en(en), .eng_active(eng_active), .eng_pop(eng_pop), .eng_push(eng_push),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .imask(imask), .irq_err(irq_err)
);

// File: tb/spi_reg_frontend_bench.sv
module spi_reg_frontend_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0] wr_half = 2'b11;
  logic [31:0] rdata;
  logic eng_active, eng_tx_avail;
  logic [15:0] eng_tx_data;
  logic eng_pop = 1'b0, eng_push = 1'b0;
  logic [15:0] eng_rx_data = '0;
  logic [3:0] ss_sel;
  logic irq_rx, irq_tx, irq_err;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  spi_reg_frontend u_spi_reg_frontend (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] h = 2'b11);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; wr_half = h;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; wr_half = 2'b11;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic epop();
    @(negedge clk); eng_pop = 1'b1;
    @(negedge clk); eng_pop = 1'b0;
  endtask

  task automatic epush(input logic [15:0] d);
    @(negedge clk); eng_push = 1'b1; eng_rx_data = d;
    @(negedge clk); eng_push = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 4'h0, 0);
    rd_chk("R1 en", 4'h2, 0);
    rd_chk("R1 thr", 4'h5, 0);
    rd_chk("R1 imr", 4'hb, 0);
    rd_chk("R1 txl", 4'h7, 0);
    rd_chk("R1 rxl", 4'h8, 0);
    rd_chk("R1 sr", 4'h9, 32'h06);
    chk("R1 irq", {irq_rx, irq_tx, irq_err}, 0);
  endtask

  task automatic t_decode();
    wr(4'h4, 32'h1234);
    rd_chk("R2 baud", 4'h4, 32'h1234);
    rd_chk("R2 hole 0x1", 4'h1, 0);
    rd_chk("R2 hole 0xe", 4'he, 0);
  endtask

  task automatic t_clock();
    wr(4'h0, 32'h0000_00ab);
    rd_chk("R3 cfg write", 4'h0, 32'h00ab);
    wr(4'h0, 32'h0001_8000);
    rd_chk("R3 gate set", 4'h0, 32'h80ab);
    wr(4'h0, 32'h0000_0055);
    rd_chk("R3 gate kept", 4'h0, 32'h8055);
    chk("R3 inactive when disabled", eng_active, 0);
  endtask

  task automatic t_enable();
    wr(4'h2, 32'hA1);
    rd_chk("R4 en read", 4'h2, 32'hA1);
    chk("R4 ss_sel", ss_sel, 4'hA);
    chk("R4 active", eng_active, 1);
  endtask

  task automatic t_thresh();
    wr(4'h5, 32'h0003_0002, 2'b11);
    rd_chk("R5 both", 4'h5, 32'h0003_0002);
    wr(4'h5, 32'hFFFF_0005, 2'b01);
    rd_chk("R5 low only", 4'h5, 32'h0003_0005);
    wr(4'h5, 32'h0006_FFFF, 2'b10);
    rd_chk("R5 high only", 4'h5, 32'h0006_0005);
    wr(4'h5, 32'h0001_0001, 2'b11);
  endtask

  task automatic t_gate();
    wr(4'h0, 32'h0001_0000);
    wr(4'hd, 32'hC000_0011);
    wr(4'hd, 32'hC000_0022);
    epop();
    rd_chk("R3 gated pop ignored", 4'h7, 2);
    epush(16'h0099);
    rd_chk("R3 gated push ignored", 4'h8, 0);
    wr(4'h0, 32'h0001_8000);
  endtask

  task automatic t_fifo();
    wr(4'hd, 32'hC000_0033);
    rd_chk("R6 txl", 4'h7, 3);
    chk("R6 head", eng_tx_data, 16'h0011);
    epop();
    chk("R6 next", eng_tx_data, 16'h0022);
    rd_chk("R6 txl after pop", 4'h7, 2);
    epush(16'h005a);
    epush(16'h005b);
    wr(4'hd, 32'h8000_0000);
    rd_chk("R7 first", 4'hd, 32'h5a);
    wr(4'hd, 32'h8000_0000);
    rd_chk("R7 second", 4'hd, 32'h5b);
    epush(16'h0077);
    wr(4'hd, 32'h4000_0000);
    wr(4'hd, 32'h0000_0044);
    rd_chk("R8 txl", 4'h7, 2);
    rd_chk("R8 rxl", 4'h8, 1);
    rd_chk("R8 hold", 4'hd, 32'h5b);
    wr(4'hd, 32'h8000_0000);
  endtask

  task automatic t_limits();
    for (int i = 0; i < 6; i++) wr(4'hd, 32'hC000_0100 + i);
    rd_chk("R9 tx full", 4'h7, 8);
    wr(4'hd, 32'hC000_0dea);
    rd_chk("R9 tx still full", 4'h7, 8);
    wr(4'hd, 32'h8000_0000);
    rd_chk("R9 underflow zero", 4'hd, 0);
    for (int i = 0; i < 9; i++) epush(16'h0200 + 16'(i));
    rd_chk("R9 rx full", 4'h8, 8);
    rd_chk("R13 sr full", 4'h9, 32'h19);
  endtask

  task automatic t_irq();
    wr(4'hb, 32'h1f);
    rd_chk("R10 isr all", 4'ha, 32'h1e);
    chk("R11 lines", {irq_rx, irq_tx, irq_err}, 3'b101);
    wr(4'hb, 32'h10);
    chk("R11 rx only", {irq_rx, irq_tx, irq_err}, 3'b100);
    wr(4'hb, 32'h1f);
    wr(4'hc, 32'h02);
    rd_chk("R10 clear one", 4'ha, 32'h1c);
    wr(4'hc, 32'h1f);
    rd_chk("R10 clear all", 4'ha, 32'h10);
    chk("R11 err low", irq_err, 0);
  endtask

  task automatic t_flush();
    wr(4'h2, 32'h00);
    rd_chk("R12 txl", 4'h7, 0);
    rd_chk("R12 rxl", 4'h8, 0);
    rd_chk("R13 sr idle", 4'h9, 32'h06);
    wr(4'h2, 32'h01);
    rd_chk("R10 txe live", 4'ha, 32'h01);
    chk("R11 tx line", {irq_rx, irq_tx, irq_err}, 3'b010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_clock();
    t_enable();
    t_thresh();
    t_gate();
    t_fifo();
    t_limits();
    t_irq();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule